// File: doc/BRIEF.md
# Interrupt Remap Table Pointer Register Slice

This block is the register slice of an I/O translation unit that holds where the interrupt-remapping table lives in memory and how many entries it has. Software programs a 64-bit table-pointer register. It can do this with one 8-byte write or with two 4-byte writes, one to a low offset and one to a high offset. Programming this register on its own has no effect on the pointer that the rest of the unit uses.

Software makes a programmed value live by writing the global command register with the set-pointer bit set. On that command the slice copies the stored register into two outputs: the table base, which is the register with its low 12 bits cleared, and the entry count, which is two raised to the power of the size field plus one. It then reports completion through a sticky bit in the global status register and a one-cycle done pulse.

All accesses use a single request port that carries an address offset, a byte count, write data and a write flag. Read data returns one cycle after the request.

Top module: `irt_ptr_regs`

## Requirements
- R1: After reset, the pointer register reads zero at both offsets. The base output, count output, status bit, done pulse and error flag are all zero.
- R2: Only bits 63:12 and 3:0 of the pointer register store written data. Bits 11:4 always read zero, and this includes the extended-mode enable bit, which is not supported.
- R3: At the low offset (0x20), a write with byte count 8 updates all 64 bits. A write with any other byte count updates bits 31:0 only.
- R4: At the high offset (0x24), a write with byte count 4 updates bits 63:32 and leaves bits 31:0 unchanged.
- R5: At the high offset, a write whose byte count is not 4 leaves the register unchanged. It raises err_o for exactly the one cycle after the request.
- R6: Read data appears on rdata_o in the cycle after the request. An 8-byte read at the low offset returns the full register. Any other read at the low offset returns bits 31:0 zero-extended. A read at the high offset returns bits 63:32 in bits 31:0, with the upper half zero.
- R7: A write to the command offset (0x00) with bit SETPTR_BIT (default 24) set captures the pointer register as it stands. One cycle after the request, tbl_base_o shows the register with bits 11:0 cleared and tbl_cnt_o shows 2^(bits 3:0 + 1).
- R8: tbl_base_o and tbl_cnt_o change only on a set-pointer command. Writes to the pointer register, command writes without the bit, and reads leave them unchanged.
- R9: The status register (offset 0x04) reads the pointer-status flag at bit SETPTR_BIT and zero elsewhere. The flag is set by the first set-pointer command and stays set until reset. Writes to the status offset do not change it.
- R10: latch_done_o is high for exactly the one cycle in which the new base and count first appear.
- R11: A later set-pointer command captures the pointer register again, so the outputs follow the register value at the time of that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, one access per cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Register byte offset |
| req_size_i | input | 4 | Access byte count (4 or 8) |
| req_wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, one cycle after the read request |
| err_o | output | 1 | One-cycle pulse after a bad-sized high-offset write |
| tbl_base_o | output | 64 | Captured table base address |
| tbl_cnt_o | output | 17 | Captured entry count |
| latch_done_o | output | 1 | One-cycle pulse on capture |

## Verification
Every result of this block is due exactly one clock edge after the request that causes it. That covers read data, the error pulse, the captured base and count, the status flag and the done pulse. The bench drives each request on the falling edge, lets one rising edge pass, and then samples all outputs a little after that edge. It then drops the request before the next edge. As a result, each observation belongs to exactly one request. Over a seeded random sequence of writes, reads and commands, a bench model predicts the register, the captured values and the pulses for that single cycle. The bench also checks that both pulses have fallen again once an idle cycle has passed.

// File: rtl/irt_ptr_pkg.sv
package irt_ptr_pkg;
  localparam int unsigned DW       = 64;
  localparam int unsigned FLD_W    = 4;
  localparam int unsigned CNT_W    = (1 << FLD_W) + 1;
  localparam int unsigned BASE_LSB = 12;
  localparam int unsigned HALF     = DW / 2;
  localparam logic [DW-1:0] WR_MASK  = ~(64'hFF << 4);
  localparam logic [DW-1:0] BASE_MASK = ~((64'h1 << BASE_LSB) - 64'h1);

  typedef struct packed {
    logic wr_lo_full;
    logic wr_lo_half;
    logic wr_hi;
    logic wr_hi_bad;
    logic wr_cmd;
    logic rd_lo64;
    logic rd_lo32;
    logic rd_hi;
    logic rd_sts;
    logic rd_any;
  } req_dec_t;

  function automatic logic [CNT_W-1:0] entry_count(input logic [FLD_W-1:0] fld);
    int unsigned sh;
    sh = int'(fld) + 1;
    return CNT_W'(1) << sh;
  endfunction
endpackage

// File: rtl/irt_req_dec.sv
module irt_req_dec
  import irt_ptr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned OFF_CMD = 'h00,
  parameter int unsigned OFF_STS = 'h04,
  parameter int unsigned OFF_LO  = 'h20,
  parameter int unsigned OFF_HI  = 'h24
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        size_i,
  output req_dec_t          dec_o
);
  logic is_cmd, is_sts, is_lo, is_hi, sz8, sz4, wr, rd;

  always_comb begin
    is_cmd = (addr_i == ADDR_W'(OFF_CMD));
    is_sts = (addr_i == ADDR_W'(OFF_STS));
    is_lo  = (addr_i == ADDR_W'(OFF_LO));
    is_hi  = (addr_i == ADDR_W'(OFF_HI));
    sz8    = (size_i == 4'd8);
    sz4    = (size_i == 4'd4);
    wr     = valid_i & write_i;
    rd     = valid_i & ~write_i;

    dec_o.wr_lo_full = wr & is_lo & sz8;
    dec_o.wr_lo_half = wr & is_lo & ~sz8;
    dec_o.wr_hi      = wr & is_hi & sz4;
    dec_o.wr_hi_bad  = wr & is_hi & ~sz4;
    dec_o.wr_cmd     = wr & is_cmd;
    dec_o.rd_lo64    = rd & is_lo & sz8;
    dec_o.rd_lo32    = rd & is_lo & ~sz8;
    dec_o.rd_hi      = rd & is_hi;
    dec_o.rd_sts     = rd & is_sts;
    dec_o.rd_any     = rd;
  end
endmodule

// File: rtl/irt_addr_reg.sv
module irt_addr_reg
  import irt_ptr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  req_dec_t      dec_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] val_o,
  output logic          err_o
);
  logic [DW-1:0] val_q, val_d;
  logic          err_q;

  always_comb begin
    val_d = val_q;
    if (dec_i.wr_lo_full)      val_d = wdata_i;
    else if (dec_i.wr_lo_half) val_d[HALF-1:0] = wdata_i[HALF-1:0];
    else if (dec_i.wr_hi)      val_d[DW-1:HALF] = wdata_i[HALF-1:0];
    val_d = val_d & WR_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      err_q <= 1'b0;
    end else begin
      val_q <= val_d;
      err_q <= dec_i.wr_hi_bad;
    end
  end

  assign val_o = val_q;
  assign err_o = err_q;

  // R5: bad-sized high write is dropped and flagged
  p_hi_bad_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i.wr_hi_bad |=> err_q && $stable(val_q));
  // R4: high write keeps the low half
  p_hi_keeps_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i.wr_hi |=> $stable(val_q[HALF-1:0]));
  // R3: half write keeps the high half
  p_lo_half_keeps_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i.wr_lo_half |=> $stable(val_q[DW-1:HALF]));
endmodule

// File: rtl/irt_ptr_latch.sv
module irt_ptr_latch
  import irt_ptr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [DW-1:0]    reg_val_i,
  output logic [DW-1:0]    base_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sts_o,
  output logic             done_o
);
  logic [DW-1:0]    base_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sts_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      sts_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= set_i;
      if (set_i) begin
        base_q <= reg_val_i & BASE_MASK;
        cnt_q  <= entry_count(reg_val_i[FLD_W-1:0]);
        sts_q  <= 1'b1;
      end
    end
  end

  assign base_o = base_q;
  assign cnt_o  = cnt_q;
  assign sts_o  = sts_q;
  assign done_o = done_q;

  // R8: captured values hold without a command
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i |=> $stable(base_q) && $stable(cnt_q));
  // R9: status is sticky
  p_sts_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_q |=> sts_q);
  // R10: done accompanies the capture, for one cycle
  p_done_with_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> done_q && sts_q);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !set_i) |=> !done_q);
  // R7: count is a single power of two after capture
  p_cnt_pow2_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ($countones(cnt_q) == 1));
endmodule

// File: rtl/irt_rd_path.sv
module irt_rd_path
  import irt_ptr_pkg::*;
#(
  parameter int unsigned SETPTR_BIT = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  req_dec_t      dec_i,
  input  logic [DW-1:0] reg_val_i,
  input  logic          sts_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = '0;
    if (dec_i.rd_lo64)      rdata_d = reg_val_i;
    else if (dec_i.rd_lo32) rdata_d[HALF-1:0] = reg_val_i[HALF-1:0];
    else if (dec_i.rd_hi)   rdata_d[HALF-1:0] = reg_val_i[DW-1:HALF];
    else if (dec_i.rd_sts)  rdata_d[SETPTR_BIT] = sts_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rdata_q <= '0;
    else if (dec_i.rd_any) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  // R6: high-offset reads return only the upper half, shifted down
  p_hi_read_upper_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i.rd_hi |=> (rdata_q[DW-1:HALF] == '0));
  // R2: reserved bits never appear on a register read
  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i.rd_lo64 |=> (rdata_q[11:4] == '0));
endmodule

// File: rtl/irt_ptr_regs.sv
module irt_ptr_regs
  import irt_ptr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned OFF_CMD    = 'h00,
  parameter int unsigned OFF_STS    = 'h04,
  parameter int unsigned OFF_LO     = 'h20,
  parameter int unsigned OFF_HI     = 'h24,
  parameter int unsigned SETPTR_BIT = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [3:0]        req_size_i,
  input  logic [63:0]       req_wdata_i,
  output logic [63:0]       rdata_o,
  output logic              err_o,
  output logic [63:0]       tbl_base_o,
  output logic [16:0]       tbl_cnt_o,
  output logic              latch_done_o
);
  req_dec_t      dec;
  logic [DW-1:0] reg_val;
  logic          sts, set_ptr;

  irt_req_dec #(
    .ADDR_W (ADDR_W), .OFF_CMD(OFF_CMD), .OFF_STS(OFF_STS),
    .OFF_LO (OFF_LO), .OFF_HI (OFF_HI)
  ) u_dec (
    .valid_i(req_valid_i), .write_i(req_write_i),
    .addr_i (req_addr_i),  .size_i (req_size_i),
    .dec_o  (dec)
  );

  irt_addr_reg u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .dec_i(dec),
    .wdata_i(req_wdata_i), .val_o(reg_val), .err_o(err_o)
  );

  // other command bits have no effect here; set-pointer is acted on last
  assign set_ptr = dec.wr_cmd & req_wdata_i[SETPTR_BIT];

  irt_ptr_latch u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_ptr),
    .reg_val_i(reg_val), .base_o(tbl_base_o), .cnt_o(tbl_cnt_o),
    .sts_o(sts), .done_o(latch_done_o)
  );

  irt_rd_path #(.SETPTR_BIT(SETPTR_BIT)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .dec_i(dec),
    .reg_val_i(reg_val), .sts_i(sts), .rdata_o(rdata_o)
  );

  // R1: nothing is captured while the status flag is clear
  p_no_capture_before_sts_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts |-> (tbl_cnt_o == '0) && (tbl_base_o == '0));
endmodule

// File: tb/irt_ptr_regs_bench.sv
module irt_ptr_regs_bench;
  localparam logic [7:0] A_CMD = 8'h00, A_STS = 8'h04, A_LO = 8'h20, A_HI = 8'h24;
  localparam int SB = 24;
  localparam logic [63:0] MSK = 64'hFFFF_FFFF_FFFF_F00F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v = 1'b0, w = 1'b0;
  logic [7:0]  a = '0;
  logic [3:0]  sz = '0;
  logic [63:0] wd = '0;
  logic [63:0] rdata, base;
  logic [16:0] cnt;
  logic        err, done;

  int total = 0, bad = 0;
  logic [63:0] m_reg = '0, m_base = '0;
  logic [16:0] m_cnt = '0;
  logic        m_sts = 1'b0;

  always #2 clk = ~clk;

  irt_ptr_regs u_irt_ptr_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v), .req_write_i(w),
    .req_addr_i(a), .req_size_i(sz), .req_wdata_i(wd), .rdata_o(rdata),
    .err_o(err), .tbl_base_o(base), .tbl_cnt_o(cnt), .latch_done_o(done)
  );

  function automatic logic [16:0] f_cnt(input logic [63:0] r);
    return 17'(1) << (int'(r[3:0]) + 1);
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] ad, input logic [3:0] s, input logic [63:0] d);
    @(negedge clk);
    v = 1'b1; w = wr; a = ad; sz = s; wd = d;
    @(posedge clk); #1;
    @(negedge clk);
    v = 1'b0;
  endtask

  // write plus model update and post-edge checks
  task automatic do_wr(input logic [7:0] ad, input logic [3:0] s, input logic [63:0] d);
    logic e_err, e_done;
    e_err = 1'b0; e_done = 1'b0;
    @(negedge clk);
    v = 1'b1; w = 1'b1; a = ad; sz = s; wd = d;
    if (ad == A_LO) begin
      if (s == 4'd8) m_reg = d & MSK;
      else m_reg = {m_reg[63:32], d[31:0]} & MSK;
    end else if (ad == A_HI) begin
      if (s == 4'd4) m_reg = {d[31:0], m_reg[31:0]} & MSK;
      else e_err = 1'b1;
    end else if (ad == A_CMD && d[SB]) begin
      m_base = m_reg & ~64'hFFF; m_cnt = f_cnt(m_reg); m_sts = 1'b1; e_done = 1'b1;
    end
    @(posedge clk); #1;
    chk("R5 err", 64'(err), 64'(e_err));
    chk("R10 done", 64'(done), 64'(e_done));
    chk("R7/R8/R11 base", base, m_base);
    chk("R7/R8/R11 cnt", 64'(cnt), 64'(m_cnt));
    @(negedge clk);
    v = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] ad, input logic [3:0] s, input string tag);
    logic [63:0] e;
    if (ad == A_LO) e = (s == 4'd8) ? m_reg : {32'h0, m_reg[31:0]};
    else if (ad == A_HI) e = {32'h0, m_reg[63:32]};
    else if (ad == A_STS) e = 64'(m_sts) << SB;
    else e = '0;
    @(negedge clk);
    v = 1'b1; w = 1'b0; a = ad; sz = s; wd = '0;
    @(posedge clk); #1;
    chk(tag, rdata, e);
    chk("R8 base hold", base, m_base);
    @(negedge clk);
    v = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'h1BAD_5EED;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 base", base, 64'h0);
    chk("R1 cnt", 64'(cnt), 64'h0);
    chk("R1 done", 64'(done), 64'h0);
    chk("R1 err", 64'(err), 64'h0);
    @(negedge clk) rst_n = 1'b1;
    do_rd(A_LO, 4'd8, "R1 reg lo");
    do_rd(A_STS, 4'd4, "R1 sts");

    // directed corners
    do_wr(A_LO, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    do_rd(A_LO, 4'd8, "R2 reserved bits zero");
    do_wr(A_LO, 4'd4, 64'hAAAA_AAAA_1234_5678);
    do_rd(A_LO, 4'd8, "R3 half write");
    do_wr(A_HI, 4'd4, 64'h0000_0000_CAFE_F00D);
    do_rd(A_HI, 4'd4, "R4 high write");
    do_rd(A_LO, 4'd4, "R6 low half read");
    do_wr(A_HI, 4'd8, 64'h1111_2222_3333_4444);
    do_rd(A_LO, 4'd8, "R5 bad write ignored");
    @(posedge clk); #1;
    chk("R5 err one cycle", 64'(err), 64'h0);
    do_wr(A_CMD, 4'd4, 64'h0);
    do_rd(A_STS, 4'd4, "R9 no bit no status");
    do_wr(A_LO, 4'd8, 64'h0000_0001_0000_300F);
    do_wr(A_CMD, 4'd4, 64'(1) << SB);
    @(posedge clk); #1;
    chk("R10 done falls", 64'(done), 64'h0);
    chk("R7 max count", 64'(cnt), 64'h1_0000);
    do_wr(A_STS, 4'd4, 64'h0);
    do_rd(A_STS, 4'd4, "R9 sticky status");
    do_wr(A_LO, 4'd8, 64'h0000_0000_0000_5000);
    do_rd(A_STS, 4'd4, "R8 reg write no capture");
    do_wr(A_CMD, 4'd4, (64'(1) << SB) | 64'h3);
    do_rd(A_STS, 4'd4, "R11 recapture keeps status");

    for (int i = 0; i < 400; i++) begin
      logic [63:0] d;
      int unsigned op;
      d = {$urandom, $urandom};
      op = $urandom % 9;
      case (op)
        0: do_wr(A_LO, 4'd8, d);
        1: do_wr(A_LO, 4'd4, d);
        2: do_wr(A_HI, 4'd4, d);
        3: do_wr(A_HI, ($urandom % 2) ? 4'd8 : 4'd2, d);
        4: do_wr(A_CMD, 4'd4, d);
        5: do_rd(A_LO, 4'd8, "R6 rand lo64");
        6: do_rd(A_LO, 4'd4, "R6 rand lo32");
        7: do_rd(A_HI, 4'd4, "R6 rand hi");
        default: do_rd(A_STS, 4'd4, "R9 rand sts");
      endcase
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule